// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target end of a two-wire serial memory bus. It watches clock and data lines that a system clock domain has already synchronised. It recognises bus start and stop conditions and answers only when the seven upper bits of the control byte carry its device code and the two strap inputs. A write transfer carries a two-byte word address followed by any number of data bytes. A read transfer streams bytes from the current address, with or without a preceding address phase.

Data bytes of a write are gathered in a one-page buffer. They are copied into the byte array only after the stop condition that closes the transfer. The copy happens during a modelled internal write cycle, which lasts a parameterised number of system clocks. While that cycle runs, the block reports busy and ignores its own control byte. A write-protect input that is high at the stop condition cancels the copy altogether.

The data line is driven as an open-drain enable: the block either pulls the line low or releases it. The level it reads back is the wired-AND of every driver on the bus.

Top module: `serial_eeprom_target`

## Requirements
- R1: A falling data edge while the clock stays high (start) restarts reception of a control byte from any state, even part way through a byte. A rising data edge while the clock stays high (stop) returns the block to idle.
- R2: The control byte is accepted only when its bits 7..1 equal 1010, 0, strap_i[1], strap_i[0]. Bit 0 selects read (1) or write (0). On a mismatch there is no acknowledge, and the data line stays released until the next start.
- R3: For each byte the block accepts, it pulls the data line low for the whole ninth clock. sda_pull_o changes only while the clock line is low.
- R4: After reset, sda_pull_o and busy_o are low and every byte of the array reads 0xFF.
- R5: The word address is sent high byte first, then low byte. Address bits at or above ADDR_BITS are ignored.
- R6: During a write, each data byte goes to the current address, and only the low 6 address bits increment. They wrap within the 64-byte page, and a later byte overwrites an earlier byte at the same location.
- R7: Written bytes reach the array only after the stop that ends the transfer. busy_o rises in the cycle after that stop is seen and stays high for exactly TWR_CYCLES clock cycles.
- R8: While busy_o is high, the control byte is not acknowledged and sda_pull_o stays low.
- R9: If wp_i is high at the stop, the array is left unchanged and busy_o does not rise.
- R10: During a read, the full address increments after each byte and wraps from the last byte of the array to address 0.
- R11: When the master answers a read byte with no-acknowledge (line high on the ninth clock), the block releases the data line and sends nothing more until the next start.
- R12: A read with no address phase starts at the address that follows the last byte read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level (wired-AND of all drivers) |
| strap_i | input | 2 | Device select straps; an unconnected strap is tied to 0 |
| wp_i | input | 1 | Write protect; high blocks every write |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| busy_o | output | 1 | High while the internal write cycle runs |

## Verification
The hardest situation to reach is a control byte that arrives while the internal write cycle is still running. The master must restart the bus immediately after the stop of a write, within the TWR_CYCLES window, and then confirm both the missing acknowledge and the exact length of the busy period. The bench follows each write stop at once with a start and a control byte, while a free-running counter tallies busy cycles. The page wrap and the end-of-array wrap are hit by directed addresses at offset 62 and at the last array address. Random writes and reads, checked against a bench memory model, cover the general case.

// File: rtl/ee_target_pkg.sv
package ee_target_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT
   } ee_state_t;

   localparam logic [3:0] DEV_TYPE = 4'b1010;
   localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/ee_bus_cond.sv
module ee_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
   parameter int  AW          = 11,
   parameter bit  CLEAR_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   import ee_target_pkg::*;
   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
   parameter int PW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [PW-1:0] widx,
   input  logic [7:0]    wdata,
   input  logic [PW-1:0] ridx,
   output logic          rvld,
   output logic [7:0]    rdata
);
   localparam int DEPTH = 1 << PW;

   logic       vld [DEPTH];
   logic [7:0] dat [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld[g] <= 1'b0;
               dat[g] <= '0;
            end else if (clr) begin
               vld[g] <= 1'b0;
            end else if (we && widx == PW'(g)) begin
               vld[g] <= 1'b1;
               dat[g] <= wdata;
            end
         end
      end
   endgenerate

   assign rvld  = vld[ridx];
   assign rdata = dat[ridx];
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
   parameter int CYCLES = 200,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   output logic          busy,
   output logic [CW-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (go) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         if (idx == CW'(CYCLES - 1)) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target #(
   parameter int ADDR_BITS  = 11,
   parameter int PAGE_BYTES = 64,
   parameter int TWR_CYCLES = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] strap_i,
   input  logic       wp_i,
   output logic       sda_pull_o,
   output logic       busy_o
);
   import ee_target_pkg::*;

   localparam int PG      = $clog2(PAGE_BYTES);
   localparam int HI_BITS = ADDR_BITS - 8;
   localparam int CW      = $clog2(TWR_CYCLES + 1);

   generate
      if (ADDR_BITS < 9 || ADDR_BITS > 16) begin : g_bad_aw
         $error("ADDR_BITS must lie in 9..16");
      end
      if ((1 << PG) != PAGE_BYTES || PG >= ADDR_BITS) begin : g_bad_pg
         $error("PAGE_BYTES must be a power of two below the array size");
      end
      if (TWR_CYCLES < PAGE_BYTES) begin : g_bad_twr
         $error("TWR_CYCLES must cover one page of commit cycles");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;

   ee_bus_cond u_cond (
      .clk, .rst_n, .scl_i, .sda_i,
      .scl_rise, .scl_fall, .start_det, .stop_det
   );

   ee_state_t            st;
   logic [3:0]           bit_cnt;
   logic                 ack_ph;
   logic [7:0]           shreg;
   logic [7:0]           txd;
   logic                 rw;
   logic                 mack;
   logic [HI_BITS-1:0]   ahi;
   logic [ADDR_BITS-1:0] addr;
   logic                 pull;
   logic                 wr_pend;
   logic [ADDR_BITS-PG-1:0] commit_page;
   logic                 tmr_go;
   logic                 pb_we, pb_clr;
   logic [PG-1:0]        pb_widx;
   logic [7:0]           pb_wdata;

   logic          busy;
   logic [CW-1:0] tmr_idx;
   logic          pb_rvld;
   logic [7:0]    pb_rdata;
   logic [7:0]    rd_byte;
   logic          mem_we;
   logic          in_page;

   ee_wr_timer #(.CYCLES(TWR_CYCLES)) u_tmr (
      .clk, .rst_n, .go(tmr_go), .busy, .idx(tmr_idx)
   );

   ee_page_buf #(.PW(PG)) u_pbuf (
      .clk, .rst_n,
      .clr(pb_clr), .we(pb_we), .widx(pb_widx), .wdata(pb_wdata),
      .ridx(tmr_idx[PG-1:0]), .rvld(pb_rvld), .rdata(pb_rdata)
   );

   assign in_page = tmr_idx < CW'(PAGE_BYTES);
   assign mem_we  = busy && in_page && pb_rvld;

   ee_byte_store #(.AW(ADDR_BITS), .CLEAR_RESET(1'b1)) u_mem (
      .clk, .rst_n,
      .we(mem_we), .waddr({commit_page, tmr_idx[PG-1:0]}), .wdata(pb_rdata),
      .raddr(addr), .rdata(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         bit_cnt     <= '0;
         ack_ph      <= 1'b0;
         shreg       <= '0;
         txd         <= '0;
         rw          <= 1'b0;
         mack        <= 1'b0;
         ahi         <= '0;
         addr        <= '0;
         pull        <= 1'b0;
         wr_pend     <= 1'b0;
         commit_page <= '0;
         tmr_go      <= 1'b0;
         pb_we       <= 1'b0;
         pb_clr      <= 1'b0;
         pb_widx     <= '0;
         pb_wdata    <= '0;
      end else begin
         tmr_go <= 1'b0;
         pb_we  <= 1'b0;
         pb_clr <= 1'b0;
         if (start_det) begin
            st      <= ST_CTRL;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
         end else if (stop_det) begin
            st      <= ST_IDLE;
            ack_ph  <= 1'b0;
            pull    <= 1'b0;
            wr_pend <= 1'b0;
            if (wr_pend && !wp_i) begin
               tmr_go      <= 1'b1;
               commit_page <= addr[ADDR_BITS-1:PG];
            end
         end else begin
            case (st)
               ST_IDLE: ;
               ST_RDAT: begin
                  if (scl_rise) begin
                     if (ack_ph) mack <= ~sda_i;
                     else        bit_cnt <= bit_cnt + 1'b1;
                  end
                  if (scl_fall) begin
                     if (ack_ph) begin
                        ack_ph <= 1'b0;
                        if (mack) begin
                           txd     <= rd_byte;
                           pull    <= ~rd_byte[7];
                           bit_cnt <= '0;
                        end else begin
                           pull <= 1'b0;
                           st   <= ST_IDLE;
                        end
                     end else if (bit_cnt == 4'd8) begin
                        pull   <= 1'b0;
                        ack_ph <= 1'b1;
                        addr   <= addr + 1'b1;
                     end else begin
                        txd  <= {txd[6:0], 1'b0};
                        pull <= ~txd[6];
                     end
                  end
               end
               default: begin
                  if (scl_rise && !ack_ph && bit_cnt != 4'd8) begin
                     shreg   <= {shreg[6:0], sda_i};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
                  if (scl_fall) begin
                     if (!ack_ph && bit_cnt == 4'd8) begin
                        pull   <= 1'b1;
                        ack_ph <= 1'b1;
                        case (st)
                           ST_CTRL: begin
                              if (shreg[7:1] == {DEV_TYPE, 1'b0, strap_i} && !busy) begin
                                 rw <= shreg[0];
                              end else begin
                                 pull   <= 1'b0;
                                 ack_ph <= 1'b0;
                                 st     <= ST_IDLE;
                              end
                           end
                           ST_AHI: ahi <= shreg[HI_BITS-1:0];
                           ST_ALO: begin
                              addr   <= {ahi, shreg};
                              pb_clr <= 1'b1;
                           end
                           default: begin
                              pb_we    <= 1'b1;
                              pb_widx  <= addr[PG-1:0];
                              pb_wdata <= shreg;
                              wr_pend  <= 1'b1;
                              addr     <= {addr[ADDR_BITS-1:PG], addr[PG-1:0] + 1'b1};
                           end
                        endcase
                     end else if (ack_ph) begin
                        pull    <= 1'b0;
                        ack_ph  <= 1'b0;
                        bit_cnt <= '0;
                        case (st)
                           ST_CTRL: begin
                              if (rw) begin
                                 st   <= ST_RDAT;
                                 txd  <= rd_byte;
                                 pull <= ~rd_byte[7];
                              end else begin
                                 st <= ST_AHI;
                              end
                           end
                           ST_AHI:  st <= ST_ALO;
                           default: st <= ST_WDAT;
                        endcase
                     end
                  end
               end
            endcase
         end
      end
   end

   assign sda_pull_o = pull;
   assign busy_o     = busy;
endmodule

// File: rtl/ee_target_checker.sv
module ee_target_checker #(
   parameter int TWR_CYCLES = 200
) (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_i,
   input logic wp_i,
   input logic sda_pull_o,
   input logic busy_o
);
   int run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_len <= 0;
      else if (busy_o) run_len <= run_len + 1;
      else             run_len <= 0;
   end

   a_r3_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_i);

   a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> ($past(scl_i) && $past(sda_i)));

   a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == TWR_CYCLES));

   a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_pull_o);

   a_r9_protect_blocks_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(wp_i));
endmodule

bind serial_eeprom_target ee_target_checker #(.TWR_CYCLES(TWR_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .wp_i(wp_i), .sda_pull_o(sda_pull_o), .busy_o(busy_o)
);

// File: tb/tb_serial_eeprom_target.sv
module tb_serial_eeprom_target;
   localparam int AB  = 11;
   localparam int MEM = 1 << AB;
   localparam int TWR = 200;
   localparam int Q   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic wp = 1'b0;
   logic pull, busy;
   wire  sda_bus = sda_m & ~pull;

   always #2.5 clk = ~clk;

   serial_eeprom_target #(.ADDR_BITS(AB), .PAGE_BYTES(64), .TWR_CYCLES(TWR)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .strap_i(strap), .wp_i(wp), .sda_pull_o(pull), .busy_o(busy)
   );

   int n_chk = 0, n_err = 0, busy_cnt = 0, ptr = 0;
   bit done = 1'b0;
   logic [7:0] refm [MEM];
   logic [7:0] wbuf [64];

   always @(negedge clk) if (busy) busy_cnt <= busy_cnt + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_start;
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_stop;
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic m_bit(input logic b, output logic r);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(Q / 2); r = sda_bus; tick(Q / 2); scl_m = 1'b0; tick(Q);
   endtask

   task automatic m_wbyte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      m_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic m_rbyte(input logic last, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, r);
         d[i] = r;
      end
      m_bit(last, r);
   endtask

   function automatic logic [7:0] ctrl(input logic rd);
      return {4'b1010, 1'b0, strap, rd};
   endfunction

   task automatic wait_idle;
      int g = 0;
      while (busy && g < 5000) begin tick(1); g++; end
   endtask

   task automatic do_write(input logic [15:0] a, input int n, input string req);
      logic ak;
      logic all = 1'b1;
      int eff = int'(a) & (MEM - 1);
      int base = eff & ~63;
      int off = eff & 63;
      m_start;
      m_wbyte(ctrl(1'b0), ak); all &= ak;
      m_wbyte(a[15:8], ak); all &= ak;
      m_wbyte(a[7:0], ak); all &= ak;
      for (int i = 0; i < n; i++) begin
         m_wbyte(wbuf[i], ak); all &= ak;
      end
      m_stop;
      check({req, " R3 write bytes acknowledged"}, 32'(all), 32'd1);
      for (int i = 0; i < n; i++)
         if (!wp) refm[base + ((off + i) & 63)] = wbuf[i];
      ptr = (n > 0) ? base + ((off + n) & 63) : eff;
   endtask

   task automatic do_read(input logic [15:0] a, input bit rnd, input int n, input string req);
      logic ak;
      logic [7:0] d;
      if (rnd) begin
         m_start;
         m_wbyte(ctrl(1'b0), ak);
         m_wbyte(a[15:8], ak);
         m_wbyte(a[7:0], ak);
         ptr = int'(a) & (MEM - 1);
      end
      m_start;
      m_wbyte(ctrl(1'b1), ak);
      check({req, " R2 read control acknowledged"}, 32'(ak), 32'd1);
      for (int i = 0; i < n; i++) begin
         m_rbyte(i == n - 1, d);
         check(req, 32'(d), 32'(refm[ptr]));
         ptr = (ptr + 1) % MEM;
      end
      m_stop;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic ak, r;
      int lows;
      void'($urandom(32'd1234));
      for (int i = 0; i < MEM; i++) refm[i] = 8'hFF;
      tick(4);
      rst_n = 1'b1;
      tick(4);
      check("R4 pull after reset", 32'(pull), 32'd0);
      check("R4 busy after reset", 32'(busy), 32'd0);
      do_read(16'h0005, 1'b1, 3, "R4 erased read");

      // R2: wrong straps, no ack and line left alone
      m_start;
      m_wbyte({4'b1010, 1'b0, strap ^ 2'b11, 1'b1}, ak);
      check("R2 foreign strap not acknowledged", 32'(ak), 32'd0);
      lows = 0;
      for (int i = 0; i < 9; i++) begin m_bit(1'b1, r); if (!r) lows++; end
      check("R2 line released after mismatch", 32'(lows), 32'd0);
      m_stop;

      // R7 R8: write, then try to talk during the write cycle
      for (int i = 0; i < 4; i++) wbuf[i] = 8'h30 + 8'(i);
      busy_cnt = 0;
      do_write(16'h0123, 4, "R7 directed write");
      check("R7 busy after stop", 32'(busy), 32'd1);
      m_start;
      m_wbyte(ctrl(1'b1), ak);
      check("R8 control ignored while busy", 32'(ak), 32'd0);
      m_stop;
      wait_idle;
      tick(2);
      check("R7 busy length", 32'(busy_cnt), 32'(TWR));
      do_read(16'h0123, 1'b1, 2, "R5 R10 random read");
      do_read(16'h0000, 1'b0, 2, "R12 current address read");

      // R6: page wrap on write
      for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i);
      do_write(16'h00BE, 5, "R6 page wrap write");
      wait_idle;
      do_read(16'h00BE, 1'b1, 2, "R6 page tail");
      do_read(16'h0080, 1'b1, 4, "R6 page head after wrap");

      // R5: high address bits ignored
      wbuf[0] = 8'h5C; wbuf[1] = 8'hC5;
      do_write(16'hFFC1, 2, "R5 high bits write");
      wait_idle;
      do_read(16'h07C1, 1'b1, 2, "R5 high bits ignored");

      // R10: read wraps at end of array
      wbuf[0] = 8'h77;
      do_write(16'h0000, 1, "R10 seed address 0");
      wait_idle;
      do_read(16'h07FE, 1'b1, 4, "R10 end of array wrap");

      // R9: write protect
      wp = 1'b1;
      for (int i = 0; i < 3; i++) wbuf[i] = 8'hEE;
      busy_cnt = 0;
      do_write(16'h0123, 3, "R9 protected write");
      tick(20);
      check("R9 no busy under protect", 32'(busy_cnt), 32'd0);
      wp = 1'b0;
      do_read(16'h0123, 1'b1, 3, "R9 contents unchanged");

      // R11: master no-ack ends the read
      m_start;
      m_wbyte(ctrl(1'b1), ak);
      begin
         logic [7:0] d;
         m_rbyte(1'b1, d);
         check("R11 byte before no-ack", 32'(d), 32'(refm[ptr]));
         ptr = (ptr + 1) % MEM;
      end
      lows = 0;
      for (int i = 0; i < 9; i++) begin m_bit(1'b1, r); if (!r) lows++; end
      check("R11 line released after no-ack", 32'(lows), 32'd0);
      m_stop;

      // R1: start in the middle of a byte restarts reception
      m_start;
      m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b0, r);
      do_read(16'h00BF, 1'b1, 2, "R1 restart mid byte");

      // random traffic
      for (int it = 0; it < 12; it++) begin
         logic [15:0] a = 16'($urandom);
         int n = 1 + int'($urandom % 12);
         for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
         do_write(a, n, "R6 random write");
         wait_idle;
         do_read(16'($urandom), 1'b1, 1 + int'($urandom % 6), "R10 random read");
         do_read(a, 1'b1, n, "R6 random readback");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule